// File: doc/BRIEF.md
# Decimal Prefix Carry-Propagate Adder

This block adds two unsigned packed-BCD operands of `DIGITS` decimal digits each. It returns a `DIGITS`-digit BCD sum and one decimal carry-out. A typical use is the final stage of a decimal multiplier, where two double-width partial results meet. A 16-digit product path, for example, uses 32 digits.

Every digit position forms two candidate results at once: the plain digit sum and the digit sum plus one. At the same time it works out a generate flag and a propagate flag from excess-3 copies of its two input digits, so it does not wait for any corrected sum digit. A Kogge-Stone prefix network runs over digits, not bits, and has ceil(log2 DIGITS) levels. It turns those flags into one incoming carry per digit, and that carry picks between the two candidates. There is no carry into the lowest digit.

The adder core is purely combinational. The `REG_OUT` parameter puts a result register after it, which gives a one-cycle latency and a synchronous active-high reset.

Top module: `dec_prefix_adder`

## Requirements
- R1: One clock after the operands are presented, `sum_out` holds (A + B) mod 10^DIGITS as packed BCD, with digit k in bits [4k+3:4k], and `carry_out` is 1 exactly when A + B ≥ 10^DIGITS.
- R2: With `REG_OUT` = 1 the result appears in the cycle after the operands are sampled, and it tracks a new operand pair on every clock with no bubbles.
- R3: While `rst` is high at a rising clock edge, `sum_out` and `carry_out` become 0 on that edge, whatever the operands are.
- R4: A digit position raises generate exactly when its two operand digits add to more than 9, and propagate exactly when they add to exactly 9. The two flags never both hold.
- R5: A carry that starts in a low digit crosses any run of propagating digits above it. For example, 99…9 + 00…01 yields all zeros with `carry_out` = 1, and a carry stops at the first digit pair that adds to less than 9.
- R6: Every digit of `sum_out` is in the range 0 to 9 whenever the operands are legal BCD.
- R7: Adding zero returns the other operand unchanged, with `carry_out` = 0, so no carry enters the lowest digit.
- R8: The largest operands, 99…9 + 99…9, yield 99…98 with `carry_out` = 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional result register |
| rst | input | 1 | Synchronous active-high reset of the result register |
| a_in | input | 4*DIGITS | First operand, packed BCD, least significant digit in the low nibble |
| b_in | input | 4*DIGITS | Second operand, packed BCD |
| sum_out | output | 4*DIGITS | Packed BCD sum, modulo 10^DIGITS |
| carry_out | output | 1 | Decimal carry out of the most significant digit |

## Verification
The hardest case to reach from the ports is a carry that has to cross every level of the prefix network: one generating digit at the bottom with a propagating pair in every digit above it. Random digits almost never line up that way. The stimulus therefore builds operand pairs on purpose. It draws each upper digit of A at random and sets the matching digit of B to nine minus it, then places a generating, neutral or killing pair at a chosen position. Runs of different lengths, broken at different heights, exercise every prefix distance. Random pairs and the all-nines, all-zeros and add-one corners fill in the rest.

// File: rtl/dec_prefix_pkg.sv
package dec_prefix_pkg;
  localparam int DIGIT_W = 4;
  localparam int X3_W    = 5;

  typedef logic [DIGIT_W-1:0] bcd_digit_t;

  typedef struct packed {
    logic gen;
    logic prop;
  } gp_t;

  function automatic int tree_levels(input int n);
    int l;
    l = 0;
    while ((1 << l) < n) l++;
    return (l < 1) ? 1 : l;
  endfunction
endpackage

// File: rtl/dec_digit_pair.sv
module dec_digit_pair
  import dec_prefix_pkg::*;
(
  input  bcd_digit_t a_dig,
  input  bcd_digit_t b_dig,
  output bcd_digit_t sum_plain,
  output bcd_digit_t sum_inc,
  output gp_t        gp
);
  // excess-3 path: flags come straight from the operands
  logic [X3_W-1:0] a_x3, b_x3, x3_total;
  // binary path: candidate sum digits
  logic [X3_W-1:0] raw, raw_inc;

  always_comb begin
    a_x3     = {1'b0, a_dig} + 5'd3;
    b_x3     = {1'b0, b_dig} + 5'd3;
    x3_total = a_x3 + b_x3;
    gp.gen   = x3_total[X3_W-1];
    gp.prop  = (x3_total == 5'd15);
  end

  always_comb begin
    raw     = {1'b0, a_dig} + {1'b0, b_dig};
    raw_inc = raw + 5'd1;
    if (raw >= 5'd10) sum_plain = bcd_digit_t'(raw - 5'd10);
    else              sum_plain = raw[DIGIT_W-1:0];
    if (raw_inc >= 5'd10) sum_inc = bcd_digit_t'(raw_inc - 5'd10);
    else                  sum_inc = raw_inc[DIGIT_W-1:0];
  end

  always_comb begin
    if (a_dig <= 4'd9 && b_dig <= 4'd9) begin
      AST_GP_EXCLUSIVE: assert (!(gp.gen && gp.prop)); // R4
      AST_GEN_AGREES: assert (gp.gen == (raw >= 5'd10)); // R4
      AST_PROP_AGREES: assert (gp.prop == (raw == 5'd9)); // R4
      AST_DIGIT_RANGE: assert (sum_plain <= 4'd9 && sum_inc <= 4'd9); // R6
    end
  end
endmodule

// File: rtl/dec_prefix_tree.sv
module dec_prefix_tree
  import dec_prefix_pkg::*;
#(
  parameter int DIGITS = 32
) (
  input  gp_t [DIGITS-1:0] gp_in,
  output logic [DIGITS-1:0] carry_in_dig,
  output logic              carry_top
);
  localparam int LEVELS = tree_levels(DIGITS);

  logic [DIGITS-1:0] g_lv [0:LEVELS];
  logic [DIGITS-1:0] p_lv [0:LEVELS];

  for (genvar i = 0; i < DIGITS; i++) begin : g_seed
    assign g_lv[0][i] = gp_in[i].gen;
    assign p_lv[0][i] = gp_in[i].prop;
  end

  for (genvar lv = 0; lv < LEVELS; lv++) begin : g_level
    localparam int DIST = 1 << lv;
    for (genvar i = 0; i < DIGITS; i++) begin : g_node
      if (i >= DIST) begin : g_merge
        assign g_lv[lv+1][i] = g_lv[lv][i] | (p_lv[lv][i] & g_lv[lv][i-DIST]);
        assign p_lv[lv+1][i] = p_lv[lv][i] & p_lv[lv][i-DIST];
      end else begin : g_pass
        assign g_lv[lv+1][i] = g_lv[lv][i];
        assign p_lv[lv+1][i] = p_lv[lv][i];
      end
    end
  end

  // no carry enters digit 0
  assign carry_in_dig = {g_lv[LEVELS][DIGITS-2:0], 1'b0};
  assign carry_top    = g_lv[LEVELS][DIGITS-1];

  logic unused_p;
  assign unused_p = ^p_lv[LEVELS];
endmodule

// File: rtl/dec_carry_select.sv
module dec_carry_select
  import dec_prefix_pkg::*;
#(
  parameter int DIGITS = 32
) (
  input  bcd_digit_t [DIGITS-1:0] plain_dig,
  input  bcd_digit_t [DIGITS-1:0] inc_dig,
  input  logic [DIGITS-1:0]       carry_in_dig,
  output bcd_digit_t [DIGITS-1:0] sum_dig
);
  for (genvar i = 0; i < DIGITS; i++) begin : g_sel
    assign sum_dig[i] = carry_in_dig[i] ? inc_dig[i] : plain_dig[i];
  end
endmodule

// File: rtl/dec_prefix_adder.sv
module dec_prefix_adder
  import dec_prefix_pkg::*;
#(
  parameter int DIGITS  = 32,
  parameter bit REG_OUT = 1'b1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [4*DIGITS-1:0]   a_in,
  input  logic [4*DIGITS-1:0]   b_in,
  output logic [4*DIGITS-1:0]   sum_out,
  output logic                  carry_out
);
  localparam int W = DIGIT_W * DIGITS;

  bcd_digit_t [DIGITS-1:0] a_dig, b_dig, plain_dig, inc_dig, sel_dig;
  gp_t        [DIGITS-1:0] gp;
  logic       [DIGITS-1:0] cin_dig;
  logic                    cout_comb;
  logic       [W-1:0]      sum_comb;

  assign a_dig = a_in;
  assign b_dig = b_in;

  for (genvar i = 0; i < DIGITS; i++) begin : g_digit
    dec_digit_pair u_pair (
      .a_dig    (a_dig[i]),
      .b_dig    (b_dig[i]),
      .sum_plain(plain_dig[i]),
      .sum_inc  (inc_dig[i]),
      .gp       (gp[i])
    );
  end

  dec_prefix_tree #(.DIGITS(DIGITS)) u_tree (
    .gp_in       (gp),
    .carry_in_dig(cin_dig),
    .carry_top   (cout_comb)
  );

  dec_carry_select #(.DIGITS(DIGITS)) u_sel (
    .plain_dig   (plain_dig),
    .inc_dig     (inc_dig),
    .carry_in_dig(cin_dig),
    .sum_dig     (sel_dig)
  );

  assign sum_comb = sel_dig;

  if (REG_OUT) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst) begin
        sum_out   <= '0;
        carry_out <= 1'b0;
      end else begin
        sum_out   <= sum_comb;
        carry_out <= cout_comb;
      end
    end

    AST_RESET_CLEARS: assert property (@(posedge clk)
      rst |=> (sum_out == '0 && !carry_out)); // R3
    AST_ZERO_IDENTITY: assert property (@(posedge clk) disable iff (rst)
      ($past(b_in) == '0 && !$past(rst)) |-> (sum_out == $past(a_in) && !carry_out)); // R7
    AST_HOLD_ON_STABLE: assert property (@(posedge clk) disable iff (rst)
      ($stable(a_in) && $stable(b_in) && !$past(rst)) |=> ($stable(sum_out) && $stable(carry_out))); // R2
    for (genvar i = 0; i < DIGITS; i++) begin : g_chk
      AST_OUT_DIGIT_LEGAL: assert property (@(posedge clk) disable iff (rst)
        sum_out[4*i +: 4] <= 4'd9); // R6
    end
  end else begin : g_comb
    assign sum_out   = sum_comb;
    assign carry_out = cout_comb;
    logic unused_clk;
    assign unused_clk = clk ^ rst;
  end
endmodule

// File: tb/dec_prefix_adder_test.sv
module dec_prefix_adder_test;
  localparam int DIGITS = 32;
  localparam int W = 4 * DIGITS;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [W-1:0] a_in = '0;
  logic [W-1:0] b_in = '0;
  logic [W-1:0] sum_out;
  logic carry_out;

  int checks = 0;
  int fails = 0;

  logic [W-1:0] exp_sum;
  logic         exp_c;
  string        exp_tag;
  bit           have_exp = 1'b0;

  always #2 clk = ~clk; // 250 MHz

  dec_prefix_adder #(.DIGITS(DIGITS), .REG_OUT(1'b1)) uut (
    .clk(clk), .rst(rst), .a_in(a_in), .b_in(b_in),
    .sum_out(sum_out), .carry_out(carry_out)
  );

  // behavioural reference: digit-serial schoolbook addition
  task automatic ref_add(input logic [W-1:0] a, input logic [W-1:0] b,
                         output logic [W-1:0] s, output logic c);
    int carry = 0;
    s = '0;
    for (int i = 0; i < DIGITS; i++) begin
      int t = int'(a[4*i +: 4]) + int'(b[4*i +: 4]) + carry;
      s[4*i +: 4] = 4'(t % 10);
      carry = t / 10;
    end
    c = (carry != 0);
  endtask

  function automatic logic [W-1:0] rand_bcd();
    logic [W-1:0] v;
    for (int i = 0; i < DIGITS; i++) v[4*i +: 4] = 4'($urandom_range(0, 9));
    return v;
  endfunction

  function automatic logic [W-1:0] all_digits(input int d);
    logic [W-1:0] v;
    for (int i = 0; i < DIGITS; i++) v[4*i +: 4] = 4'(d);
    return v;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [W-1:0] act,
                       input logic [W-1:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  task automatic compare_pending();
    bit legal = 1'b1;
    if (!have_exp) return;
    check(sum_out == exp_sum, {exp_tag, " sum"}, sum_out, exp_sum);
    check(carry_out == exp_c, {exp_tag, " carry"}, W'(carry_out), W'(exp_c));
    for (int i = 0; i < DIGITS; i++) if (sum_out[4*i +: 4] > 4'd9) legal = 1'b0;
    check(legal, "R6 digit range", sum_out, exp_sum);
    have_exp = 1'b0;
  endtask

  // drive at negedge; the previous pair's result is already registered
  task automatic apply(input logic [W-1:0] a, input logic [W-1:0] b, input string tag);
    @(negedge clk);
    compare_pending();
    a_in = a;
    b_in = b;
    ref_add(a, b, exp_sum, exp_c);
    exp_tag = tag;
    have_exp = 1'b1;
  endtask

  // propagate run from digit lo+1 to hi, pair at lo of kind k (0 kill,1 gen)
  task automatic chain(input int lo, input int hi, input bit k, input string tag);
    logic [W-1:0] a = rand_bcd();
    logic [W-1:0] b = rand_bcd();
    for (int i = lo + 1; i <= hi; i++) b[4*i +: 4] = 4'(9 - int'(a[4*i +: 4]));
    a[4*lo +: 4] = k ? 4'd7 : 4'd2;
    b[4*lo +: 4] = k ? 4'd6 : 4'd3;
    apply(a, b, tag);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin : main
    logic [W-1:0] one;
    one = '0;
    one[0] = 1'b1;

    // R3: reset with nonzero operands
    a_in = all_digits(9);
    b_in = all_digits(9);
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(sum_out == '0, "R3 reset sum", sum_out, '0);
    check(carry_out == 1'b0, "R3 reset carry", W'(carry_out), '0);
    rst = 1'b0;

    apply('0, '0, "R7 zero plus zero");
    apply(all_digits(9), one, "R5 full ripple");
    apply(all_digits(9), all_digits(9), "R8 max operands");
    apply(one, all_digits(9), "R5 full ripple swapped");
    for (int i = 0; i < 20; i++) apply(rand_bcd(), '0, "R7 add zero");
    // R4: all-propagate without start carry must not carry
    apply(all_digits(4), all_digits(5), "R4 all propagate no carry");
    apply(all_digits(5), all_digits(5), "R4 all generate");
    for (int lo = 0; lo < DIGITS - 1; lo++) begin
      chain(lo, DIGITS - 1, 1'b1, "R5 chain to top");
      chain(lo, DIGITS - 1, 1'b0, "R5 killed chain");
      chain(0, lo + 1, 1'b1, "R5 chain broken above");
    end
    // R2: back-to-back random operands, one per clock
    for (int i = 0; i < 400; i++) apply(rand_bcd(), rand_bcd(), "R1 R2 random");

    // R3: mid-run reset overrides pending pair
    @(negedge clk);
    compare_pending();
    a_in = all_digits(9);
    b_in = all_digits(8);
    rst = 1'b1;
    @(negedge clk);
    check(sum_out == '0, "R3 mid-run reset sum", sum_out, '0);
    check(carry_out == 1'b0, "R3 mid-run reset carry", W'(carry_out), '0);
    rst = 1'b0;
    apply(all_digits(1), all_digits(8), "R1 after reset");
    @(negedge clk);
    compare_pending();

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule